// File: doc/BRIEF.md
# Overloaded Command Dispatch Router

This block executes one of eight generic three-operand extension commands whose meaning is not fixed by decode. The meaning depends on a unit number carried in the low 12 bits of the first operand and on the current privilege level. The router looks up the pair (unit, privilege) in a small routing table that is loaded at boot. On a hit, it sends the request to one of several device ports. The selector it sends combines the entry's subdevice index with the command number placed above bit 12. Both operands are forwarded unchanged, and the device's answer comes back as the command result.

Three unit numbers are handled inside the router and never reach a device. Unit 1 always answers 0 and unit 2 always answers all ones. Unit 0 and the reserved units 3 to 31 always trap. A (unit, privilege) pair with no table entry also traps. A trap is raised toward the next higher privilege level, and in machine mode with debug active it becomes a debug exception. A device that rejects a selector signals an error, which the router reports as a configuration-error trap.

Privilege encoding used on every port: 0 user, 1 supervisor, 2 hypervisor, 3 machine.

Top module: `cmd_router`

## Requirements
- R1: The unit number is `cmd_a[11:0]`. While a device request is outstanding, `dev_a` equals the full `cmd_a` and `dev_b` equals `cmd_b` of the accepted command.
- R2: An accepted command with unit 1 gives `res_done` high one cycle after acceptance, with `res_data` = 0. This holds for every opcode and privilege, whatever the table holds, and no `dev_req` is raised.
- R3: An accepted command with unit 2 gives `res_done` one cycle after acceptance with `res_data` all ones, under the same conditions as R2.
- R4: Unit 0 and units 3..31 trap one cycle after acceptance even when a table entry matches them. From privilege p < 3 the trap gives `trap_cause` = 1 (no unit) and `trap_priv` = p+1.
- R5: A trap of the R4/R6 kind raised in machine mode has `trap_priv` = 3. Its `trap_cause` is 2 (debug exception) when `debug_mode` is high and 1 otherwise.
- R6: A unit outside 0..31 with no valid table entry matching both unit and privilege traps exactly as in R4/R5.
- R7: On a table hit, `dev_req` is one-hot on the entry's device from the cycle after acceptance until that port responds. `dev_sel` = {opcode, subdevice[11:0]}, so the opcode sits at bits 14:12. These outputs stay stable while waiting.
- R8: When the addressed port raises `dev_ack`, `res_done` pulses in the next cycle with that port's `dev_rdata` slot. Slots of other ports are ignored.
- R9: When the addressed port raises `dev_err`, the router pulses `trap` in the next cycle with `trap_cause` = 3 (configuration error) and `trap_priv` = 3. Error wins over a simultaneous ack.
- R10: `res_done` and `trap` are never high together, and each is a one-cycle pulse. Exactly one of them follows each accepted command. Both are low out of reset.
- R11: When several valid entries match, the lowest table index wins. A table write affects only commands accepted after the write edge.
- R12: `busy` is high while a device request is outstanding. `cmd_valid` is ignored during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Routing-table write strobe |
| tbl_idx | input | 4 | Entry index to write |
| tbl_valid | input | 1 | Entry valid bit |
| tbl_unit | input | 12 | Entry unit number |
| tbl_priv | input | 2 | Entry privilege level |
| tbl_dev | input | 2 | Entry device port index |
| tbl_sub | input | 12 | Entry subdevice index |
| cmd_valid | input | 1 | Command issue strobe |
| cmd_op | input | 3 | Command number 0..7 |
| cmd_a | input | 32 | First operand (unit in bits 11:0) |
| cmd_b | input | 32 | Second operand |
| cur_priv | input | 2 | Current privilege level |
| debug_mode | input | 1 | Debug mode active |
| busy | output | 1 | Device request outstanding |
| dev_req | output | 4 | One-hot request per device port |
| dev_sel | output | 15 | Command selector to the device |
| dev_a | output | 32 | Forwarded first operand |
| dev_b | output | 32 | Forwarded second operand |
| dev_ack | input | 4 | Per-port result valid |
| dev_err | input | 4 | Per-port selector rejected |
| dev_rdata | input | 128 | Per-port results, port i in bits 32i+31:32i |
| res_done | output | 1 | Result pulse |
| res_data | output | 32 | Result value |
| trap | output | 1 | Trap pulse |
| trap_cause | output | 3 | 1 no unit, 2 debug, 3 configuration error |
| trap_priv | output | 2 | Privilege level that takes the trap |

## Verification
Some properties are checked on every cycle. Done and trap are mutually exclusive, the request vector is one-hot, and the selector and operands hold while the router waits. Fallback units 1 and 2 answer in exactly one cycle with the right constant, unit 0 always traps, and an ack or error turns into the matching pulse one cycle later. Other behaviour depends on what the table holds and can only be shown by the bench's scenarios. These cover the cause and target level for each privilege and debug combination, lowest-index priority among duplicate entries, a rewrite of the table taking effect, the table being ignored for units 1 and 2, and a command offered while busy being dropped.

// File: rtl/cmdr_pkg.sv
package cmdr_pkg;
  localparam int UNIT_W = 12;
  localparam int SUB_W  = 12;
  localparam int RSV_HI = 31;

  typedef enum logic [1:0] {PRV_U = 2'd0, PRV_S = 2'd1, PRV_H = 2'd2, PRV_M = 2'd3} prv_e;
  typedef enum logic [2:0] {TC_NONE = 3'd0, TC_NOUNIT = 3'd1, TC_DEBUG = 3'd2, TC_CFGERR = 3'd3} tcause_e;
  typedef enum logic [1:0] {RT_ZERO, RT_ONES, RT_DEVICE, RT_TRAP} route_e;

  // privilege level that receives a trap raised at level p
  function automatic logic [1:0] promote(input logic [1:0] p);
    return (p == PRV_M) ? PRV_M : p + 2'd1;
  endfunction

  // units that never reach a device and are not fallback constants
  function automatic logic unit_blocked(input logic [UNIT_W-1:0] u);
    return (u == '0) || ((u >= UNIT_W'(3)) && (u <= UNIT_W'(RSV_HI)));
  endfunction
endpackage

// File: rtl/route_table.sv
module route_table import cmdr_pkg::*; #(
  parameter int NENT  = 16,
  parameter int DEV_W = 2,
  localparam int IDX_W = $clog2(NENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [UNIT_W-1:0] wr_unit,
  input  logic [1:0]        wr_priv,
  input  logic [DEV_W-1:0]  wr_dev,
  input  logic [SUB_W-1:0]  wr_sub,
  input  logic [UNIT_W-1:0] lk_unit,
  input  logic [1:0]        lk_priv,
  output logic              hit,
  output logic [DEV_W-1:0]  hit_dev,
  output logic [SUB_W-1:0]  hit_sub
);
  logic              ent_v [NENT];
  logic [UNIT_W-1:0] ent_u [NENT];
  logic [1:0]        ent_p [NENT];
  logic [DEV_W-1:0]  ent_d [NENT];
  logic [SUB_W-1:0]  ent_s [NENT];
  logic [NENT-1:0]   match;

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_v[i] <= 1'b0;
        ent_u[i] <= '0;
        ent_p[i] <= '0;
        ent_d[i] <= '0;
        ent_s[i] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        ent_v[i] <= wr_valid;
        ent_u[i] <= wr_unit;
        ent_p[i] <= wr_priv;
        ent_d[i] <= wr_dev;
        ent_s[i] <= wr_sub;
      end
    end
    assign match[i] = ent_v[i] && (ent_u[i] == lk_unit) && (ent_p[i] == lk_priv);
  end

  // scan from the top so the lowest matching index is kept (R11)
  always_comb begin
    hit_dev = '0;
    hit_sub = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_dev = ent_d[i];
        hit_sub = ent_s[i];
      end
    end
  end
  assign hit = |match;
endmodule

// File: rtl/dispatch_decode.sv
module dispatch_decode import cmdr_pkg::*; (
  input  logic [UNIT_W-1:0] unit,
  input  logic [1:0]        priv,
  input  logic              dbg,
  input  logic              hit,
  output route_e            kind,
  output tcause_e           cause,
  output logic [1:0]        tgt
);
  logic no_route;
  assign no_route = unit_blocked(unit) || !hit;

  always_comb begin
    cause = TC_NONE;
    tgt   = promote(priv);
    if (unit == UNIT_W'(1))      kind = RT_ZERO;
    else if (unit == UNIT_W'(2)) kind = RT_ONES;
    else if (no_route) begin
      kind  = RT_TRAP;
      cause = ((priv == PRV_M) && dbg) ? TC_DEBUG : TC_NOUNIT;
    end else                     kind = RT_DEVICE;
  end
endmodule

// File: rtl/cmd_router.sv
module cmd_router import cmdr_pkg::*; #(
  parameter int XLEN = 32,
  parameter int NCMD = 8,
  parameter int NDEV = 4,
  parameter int NENT = 16,
  localparam int OP_W  = $clog2(NCMD),
  localparam int DEV_W = $clog2(NDEV),
  localparam int IDX_W = $clog2(NENT),
  localparam int SEL_W = SUB_W + OP_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tbl_we,
  input  logic [IDX_W-1:0]     tbl_idx,
  input  logic                 tbl_valid,
  input  logic [UNIT_W-1:0]    tbl_unit,
  input  logic [1:0]           tbl_priv,
  input  logic [DEV_W-1:0]     tbl_dev,
  input  logic [SUB_W-1:0]     tbl_sub,
  input  logic                 cmd_valid,
  input  logic [OP_W-1:0]      cmd_op,
  input  logic [XLEN-1:0]      cmd_a,
  input  logic [XLEN-1:0]      cmd_b,
  input  logic [1:0]           cur_priv,
  input  logic                 debug_mode,
  output logic                 busy,
  output logic [NDEV-1:0]      dev_req,
  output logic [SEL_W-1:0]     dev_sel,
  output logic [XLEN-1:0]      dev_a,
  output logic [XLEN-1:0]      dev_b,
  input  logic [NDEV-1:0]      dev_ack,
  input  logic [NDEV-1:0]      dev_err,
  input  logic [NDEV*XLEN-1:0] dev_rdata,
  output logic                 res_done,
  output logic [XLEN-1:0]      res_data,
  output logic                 trap,
  output logic [2:0]           trap_cause,
  output logic [1:0]           trap_priv
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  // selector: subdevice in the low field, command number above it
  function automatic logic [SEL_W-1:0] make_sel(input logic [SUB_W-1:0] sub,
                                                input logic [OP_W-1:0] op);
    return {op, sub};
  endfunction

  st_e              state;
  logic [DEV_W-1:0] dev_q;
  logic             hit;
  logic [DEV_W-1:0] hit_dev;
  logic [SUB_W-1:0] hit_sub;
  route_e           kind;
  tcause_e          cause;
  logic [1:0]       tgt;

  // named events for the assertions
  logic             accept;
  logic             resp_ack;
  logic             resp_err;
  logic [XLEN-1:0]  rdata_sel;

  assign accept    = cmd_valid && (state == ST_IDLE);
  assign busy      = (state == ST_WAIT);
  assign resp_ack  = |(dev_req & dev_ack);
  assign resp_err  = |(dev_req & dev_err);
  assign rdata_sel = dev_rdata[dev_q*XLEN +: XLEN];

  for (genvar d = 0; d < NDEV; d++) begin : g_req
    assign dev_req[d] = busy && (dev_q == DEV_W'(d));
  end

  route_table #(.NENT(NENT), .DEV_W(DEV_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_valid(tbl_valid), .wr_unit(tbl_unit),
    .wr_priv(tbl_priv), .wr_dev(tbl_dev), .wr_sub(tbl_sub),
    .lk_unit(cmd_a[UNIT_W-1:0]), .lk_priv(cur_priv),
    .hit(hit), .hit_dev(hit_dev), .hit_sub(hit_sub)
  );

  dispatch_decode u_decode (
    .unit(cmd_a[UNIT_W-1:0]), .priv(cur_priv), .dbg(debug_mode), .hit(hit),
    .kind(kind), .cause(cause), .tgt(tgt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      dev_q      <= '0;
      dev_sel    <= '0;
      dev_a      <= '0;
      dev_b      <= '0;
      res_done   <= 1'b0;
      res_data   <= '0;
      trap       <= 1'b0;
      trap_cause <= TC_NONE;
      trap_priv  <= PRV_U;
    end else begin
      res_done <= 1'b0;
      trap     <= 1'b0;
      if (accept) begin
        unique case (kind)
          RT_ZERO: begin res_done <= 1'b1; res_data <= '0; end
          RT_ONES: begin res_done <= 1'b1; res_data <= '1; end
          RT_TRAP: begin trap <= 1'b1; trap_cause <= cause; trap_priv <= tgt; end
          RT_DEVICE: begin
            state   <= ST_WAIT;
            dev_q   <= hit_dev;
            dev_sel <= make_sel(hit_sub, cmd_op);
            dev_a   <= cmd_a;
            dev_b   <= cmd_b;
          end
        endcase
      end else if (busy && resp_err) begin
        state      <= ST_IDLE;
        trap       <= 1'b1;
        trap_cause <= TC_CFGERR;
        trap_priv  <= PRV_M;
      end else if (busy && resp_ack) begin
        state    <= ST_IDLE;
        res_done <= 1'b1;
        res_data <= rdata_sel;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_done && trap));

  assert_req_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_req));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !resp_ack && !resp_err) |=> ($stable(dev_sel) && $stable(dev_a) && $stable(dev_b) && $stable(dev_req)));

  assert_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_a[UNIT_W-1:0] == UNIT_W'(1)) |=> (res_done && res_data == '0 && dev_req == '0));

  assert_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_a[UNIT_W-1:0] == UNIT_W'(2)) |=> (res_done && res_data == '1));

  assert_unit0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_a[UNIT_W-1:0] == '0) |=> (trap && !res_done && trap_cause != TC_CFGERR));

  assert_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_ack && !resp_err) |=> (res_done && !busy));

  assert_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |=> (trap && trap_cause == TC_CFGERR && trap_priv == PRV_M));

  assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && !resp_ack && !resp_err) |=> (busy && !res_done && !trap));
endmodule

// File: tb/cmd_router_bench.sv
module cmd_router_bench;
  localparam int XLEN = 32;
  localparam int NDEV = 4;
  localparam int NENT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        tbl_we = 0, tbl_valid = 0;
  logic [3:0]  tbl_idx = 0;
  logic [11:0] tbl_unit = 0, tbl_sub = 0;
  logic [1:0]  tbl_priv = 0, tbl_dev = 0;
  logic        cmd_valid = 0, debug_mode = 0;
  logic [2:0]  cmd_op = 0;
  logic [31:0] cmd_a = 0, cmd_b = 0;
  logic [1:0]  cur_priv = 0;
  logic        busy;
  logic [3:0]  dev_req, dev_ack = 0, dev_err = 0;
  logic [14:0] dev_sel;
  logic [31:0] dev_a, dev_b, res_data;
  logic [127:0] dev_rdata = 0;
  logic        res_done, trap;
  logic [2:0]  trap_cause;
  logic [1:0]  trap_priv;

  cmd_router u_cmd_router (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid), .tbl_unit(tbl_unit),
    .tbl_priv(tbl_priv), .tbl_dev(tbl_dev), .tbl_sub(tbl_sub),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .cur_priv(cur_priv), .debug_mode(debug_mode),
    .busy(busy), .dev_req(dev_req), .dev_sel(dev_sel), .dev_a(dev_a), .dev_b(dev_b),
    .dev_ack(dev_ack), .dev_err(dev_err), .dev_rdata(dev_rdata),
    .res_done(res_done), .res_data(res_data), .trap(trap),
    .trap_cause(trap_cause), .trap_priv(trap_priv)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit win = 0;   // a done/trap pulse is expected in the coming cycle

  // reference table mirror
  bit          mv [NENT];
  logic [11:0] mu [NENT];
  logic [1:0]  mp [NENT];
  int          md [NENT];
  logic [11:0] ms [NENT];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-cycle comparison: no pulse outside an expected window, never both (R10)
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      checks++;
      if ((res_done && trap) || (!win && (res_done || trap))) begin
        errors++;
        $display("FAIL R10: actual done=%0b trap=%0b expected window=%0b", res_done, trap, win);
      end
    end
  end

  // behavioural model: 0 zero, 1 ones, 2 device, 3 trap
  task automatic model(input logic [11:0] u, input logic [1:0] p, input logic dbg,
                       output int kind, output logic [2:0] cause, output logic [1:0] tgt,
                       output int dev, output logic [11:0] sub);
    int found = -1;
    for (int i = 0; i < NENT; i++)
      if (found < 0 && mv[i] && mu[i] == u && mp[i] == p) found = i;
    dev = 0; sub = 0; cause = 0;
    tgt = (p == 3) ? 2'd3 : p + 2'd1;
    if (u == 1) kind = 0;
    else if (u == 2) kind = 1;
    else if (u == 0 || (u >= 3 && u <= 31) || found < 0) begin
      kind = 3;
      cause = (p == 3 && dbg) ? 3'd2 : 3'd1;
    end else begin
      kind = 2; dev = md[found]; sub = ms[found];
    end
  endtask

  task automatic write_entry(input int idx, input bit v, input logic [11:0] u,
                             input logic [1:0] p, input int d, input logic [11:0] s);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 4'(idx); tbl_valid = v; tbl_unit = u; tbl_priv = p;
    tbl_dev = 2'(d); tbl_sub = s;
    @(negedge clk);
    tbl_we = 0;
    mv[idx] = v; mu[idx] = u; mp[idx] = p; md[idx] = d; ms[idx] = s;
  endtask

  task automatic run_cmd(input string req, input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [1:0] p, input logic dbg,
                         input bit err, input int lat, input logic [31:0] rdv, input bit poke);
    int kind, dev;
    logic [2:0] cause;
    logic [1:0] tgt;
    logic [11:0] sub;
    model(a[11:0], p, dbg, kind, cause, tgt, dev, sub);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_a = a; cmd_b = b; cur_priv = p; debug_mode = dbg;
    win = (kind != 2);
    @(negedge clk);
    cmd_valid = 0;
    if (kind == 0 || kind == 1) begin
      chk({req, " done"}, res_done, 1);
      chk({req, " data"}, res_data, (kind == 0) ? 32'h0 : 32'hFFFF_FFFF);
      chk({req, " no request"}, dev_req, 0);
      win = 0;
    end else if (kind == 3) begin
      chk({req, " trap"}, trap, 1);
      chk({req, " cause"}, trap_cause, cause);
      chk({req, " target"}, trap_priv, tgt);
      win = 0;
    end else begin
      chk({req, " R7 req"}, dev_req, 4'b1 << dev);
      chk({req, " R7 sel"}, dev_sel, {op, sub});
      chk({req, " R1 a"}, dev_a, a);
      chk({req, " R1 b"}, dev_b, b);
      chk({req, " R12 busy"}, busy, 1);
      for (int k = 0; k < lat; k++) begin
        if (poke && k == 0) begin
          cmd_valid = 1; cmd_a = 32'h0000_0001; cmd_b = 32'h5;
        end
        @(negedge clk);
        cmd_valid = 0;
        chk({req, " R7 held"}, {dev_req, dev_sel}, {4'b1 << dev, op, sub});
        chk({req, " R1 a held"}, dev_a, a);
      end
      for (int i = 0; i < NDEV; i++) dev_rdata[i*32 +: 32] = 32'hBAD0_0000 | i;
      dev_rdata[dev*32 +: 32] = rdv;
      if (err) dev_err[dev] = 1; else dev_ack[dev] = 1;
      win = 1;
      @(negedge clk);
      dev_ack = 0; dev_err = 0; win = 0;
      if (err) begin
        chk({req, " R9 trap"}, trap, 1);
        chk({req, " R9 cause"}, trap_cause, 3);
        chk({req, " R9 target"}, trap_priv, 3);
      end else begin
        chk({req, " R8 done"}, res_done, 1);
        chk({req, " R8 data"}, res_data, rdv);
      end
      chk({req, " R12 idle"}, busy, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) begin mv[i] = 0; mu[i] = 0; mp[i] = 0; md[i] = 0; ms[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset done", res_done, 0);
    chk("R10 reset trap", trap, 0);
    chk("R12 reset busy", busy, 0);
    chk("R7 reset req", dev_req, 0);

    // a table entry for unit 1 and unit 5 must be ignored (R2, R4)
    write_entry(3, 1, 12'd1, 2'd0, 2, 12'h7);
    write_entry(4, 1, 12'd5, 2'd1, 1, 12'h1);

    run_cmd("R2 zero U op0", 3'd0, 32'hABCD_E001, 32'h1234, 2'd0, 0, 0, 0, 0, 0);
    run_cmd("R2 zero M op7", 3'd7, 32'h0000_0001, 32'hFFFF, 2'd3, 1, 0, 0, 0, 0);
    run_cmd("R3 ones S op4", 3'd4, 32'h7777_7002, 32'h0,    2'd1, 0, 0, 0, 0, 0);
    run_cmd("R3 ones H op1", 3'd1, 32'h0000_0002, 32'h9,    2'd2, 0, 0, 0, 0, 0);
    run_cmd("R4 unit0 U",    3'd2, 32'h1111_1000, 32'h0,    2'd0, 0, 0, 0, 0, 0);
    run_cmd("R4 unit0 H",    3'd2, 32'h0000_0000, 32'h0,    2'd2, 1, 0, 0, 0, 0);
    run_cmd("R4 unit5 S",    3'd3, 32'h0000_0005, 32'h0,    2'd1, 0, 0, 0, 0, 0);
    run_cmd("R4 unit31 U",   3'd3, 32'h0000_001F, 32'h0,    2'd0, 0, 0, 0, 0, 0);
    run_cmd("R5 unit0 M",    3'd0, 32'h0000_0000, 32'h0,    2'd3, 0, 0, 0, 0, 0);
    run_cmd("R5 unit0 M dbg", 3'd0, 32'h0000_0000, 32'h0,   2'd3, 1, 0, 0, 0, 0);

    write_entry(0, 1, 12'd40, 2'd0, 1, 12'h005);
    run_cmd("R6 wrong priv", 3'd3, 32'h0000_0028, 32'h0,    2'd1, 0, 0, 0, 0, 0);
    run_cmd("R6 unmapped M dbg", 3'd1, 32'h0000_0100, 32'h0, 2'd3, 1, 0, 0, 0, 0);
    run_cmd("R7 device U",   3'd3, 32'hCAFE_0028, 32'h0BAD_F00D, 2'd0, 0, 0, 2, 32'h1357_9BDF, 0);
    run_cmd("R7 device lat0", 3'd6, 32'h0000_0028, 32'h1, 2'd0, 0, 0, 0, 32'h2468_ACE0, 0);
    run_cmd("R9 device err", 3'd1, 32'h5555_5028, 32'h2, 2'd0, 0, 1, 1, 32'h0, 0);

    // duplicates: lowest index wins, then rewrite takes effect (R11)
    write_entry(9, 1, 12'd50, 2'd1, 3, 12'h0AA);
    write_entry(2, 1, 12'd50, 2'd1, 0, 12'h0BB);
    run_cmd("R11 lowest wins", 3'd5, 32'h0000_0032, 32'h3, 2'd1, 0, 0, 1, 32'h0000_00BB, 0);
    write_entry(2, 0, 12'd50, 2'd1, 0, 12'h0BB);
    run_cmd("R11 after rewrite", 3'd5, 32'h0000_0032, 32'h3, 2'd1, 0, 0, 1, 32'h0000_00AA, 0);

    // command offered while busy is dropped (R12)
    run_cmd("R12 poke ignored", 3'd2, 32'hF0F0_0028, 32'h44, 2'd0, 0, 0, 3, 32'h0DD0_0DD0, 1);
    repeat (2) @(negedge clk);
    chk("R12 no extra result", {res_done, trap, busy}, 3'b000);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule